// File: doc/BRIEF.md
# CPU Constant Countdown Timer

A per-core timer that turns a single 64-bit configuration word into a countdown. The word carries an enable flag, a periodic flag and an initial tick count. While enabled, the count falls by one on each pulse of a fixed-rate time base. When it runs out, the block raises an interrupt request. In periodic mode it then reloads the count from the stored word. In one-shot mode it clears the stored enable flag itself, so software can tell that the timer has stopped by reading the word back.

The time base is a clock-enable pulse divided down from the system clock. The same pulse also advances a free-running constant counter, which software can read as a timestamp. A small register port offers a configuration write, a readback selector (configuration word, ticks left, constant counter) and a strobe that clears the interrupt.

Top module: `cpu_const_timer`

## Requirements
- R1: A write stores all 64 bits of `cfg_wdata`. With `rd_sel` = 0, `rd_data` returns the stored word unchanged. Hardware never alters the word, except that a one-shot expiry clears bit 0.
- R2: A write with bit 0 set loads the tick count from bits 47..2 of the written word. Bits 1..0 and bits 63..48 count as zero. With `rd_sel` = 1, `rd_data` returns that count zero-extended.
- R3: While bit 0 of the stored word is 1, each tick pulse lowers the count by one. A tick that finds the count at 1 or 0 is the expiry. So a loaded count N ≥ 1 expires on the N-th tick after the write, and a loaded count of 0 expires on the first tick.
- R4: At an expiry with bit 1 (periodic) of the stored word set, the count reloads from bits 47..2 of the stored word and the countdown continues.
- R5: At an expiry with bit 1 clear, only bit 0 of the stored word drops to 0 and the count reads 0. No further expiry follows.
- R6: Every expiry sets `irq`. `irq` then stays 1 until a cycle with `irq_clr` high and no expiry. An expiry in the same cycle as `irq_clr` leaves `irq` at 1.
- R7: A write with bit 0 clear stops the countdown and sets the count to 0. No expiry follows from it.
- R8: A write while a countdown runs restarts it from the new value. A write in the same cycle as the tick that would have expired cancels that expiry.
- R9: The constant counter starts at 0 after reset and rises by exactly one per tick pulse. With `rd_sel` = 2 it reads zero-extended. With `rd_sel` = 3, `rd_data` reads 0.
- R10: One tick pulse occurs every `TICK_DIV` system clocks. Counter and countdown stay unchanged in the cycles between pulses.
- R11: After reset the stored word, count, constant counter and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W (64) | Configuration word to store |
| irq_clr | input | 1 | Interrupt clear strobe |
| rd_sel | input | 2 | Readback select: 0 word, 1 ticks left, 2 constant counter, 3 zero |
| rd_data | output | CFG_W (64) | Selected readback value, combinational |
| irq | output | 1 | Timer interrupt request, held until cleared |

## Verification
Two events can share one cycle. The first is an expiry and a software clear of the interrupt. The bench lines up the clear strobe with the exact tick that ends a periodic countdown, then checks that `irq` is still 1 and that the count has reloaded. It also checks that a clear in a quiet cycle drops `irq`. The second is an expiry and a configuration write. The bench issues a write on the expiring tick and checks that no interrupt appears and that the count equals the new value.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int unsigned EN_BIT  = 0;
    localparam int unsigned PER_BIT = 1;

    typedef enum logic [1:0] {
        SEL_WORD = 2'd0,
        SEL_LEFT = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_NONE = 2'd3
    } ctmr_sel_e;

endpackage

// File: rtl/ctmr_tick_gen.sv
module ctmr_tick_gen #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    typedef struct packed {
        logic [DW-1:0] div;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.div == LAST) s_d.div = '0;
        else                 s_d.div = s_q.div + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = (s_q.div == LAST);

endmodule

// File: rtl/ctmr_free_cnt.sv
module ctmr_free_cnt #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] count
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick) s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;

endmodule

// File: rtl/ctmr_countdown.sv
module ctmr_countdown
    import ctmr_pkg::*;
#(
    parameter int unsigned CFG_W  = 64,
    parameter int unsigned LEFT_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              irq_clr,
    output logic [CFG_W-1:0]  cfg_word,
    output logic [LEFT_W-1:0] left_cnt,
    output logic              irq,
    output logic              expire
);
    localparam logic [LEFT_W-1:0] ONE = LEFT_W'(1);

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic [LEFT_W-1:0] left;
        logic              irq;
    } cd_st_t;

    cd_st_t s_d, s_q;
    logic   expire_c;

    function automatic logic [LEFT_W-1:0] load_of(input logic [CFG_W-1:0] w);
        load_of = {w[LEFT_W-1:2], 2'b00};
    endfunction

    always_comb begin
        s_d      = s_q;
        expire_c = tick && s_q.cfg[EN_BIT] && (s_q.left <= ONE) && !cfg_we;

        if (cfg_we) begin
            s_d.cfg  = cfg_wdata;
            s_d.left = cfg_wdata[EN_BIT] ? load_of(cfg_wdata) : '0;
        end else if (tick && s_q.cfg[EN_BIT]) begin
            if (s_q.left <= ONE) begin
                if (s_q.cfg[PER_BIT]) begin
                    s_d.left = load_of(s_q.cfg);
                end else begin
                    s_d.cfg[EN_BIT] = 1'b0;
                    s_d.left        = '0;
                end
            end else begin
                s_d.left = s_q.left - 1'b1;
            end
        end

        s_d.irq = expire_c | (s_q.irq & ~irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_word = s_q.cfg;
    assign left_cnt = s_q.left;
    assign irq      = s_q.irq;
    assign expire   = expire_c;

endmodule

// File: rtl/cpu_const_timer.sv
module cpu_const_timer
    import ctmr_pkg::*;
#(
    parameter int unsigned TICK_DIV = 4,
    parameter int unsigned CFG_W    = 64,
    parameter int unsigned LEFT_W   = 48,
    parameter int unsigned CNT_W    = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             irq_clr,
    input  logic [1:0]       rd_sel,
    output logic [CFG_W-1:0] rd_data,
    output logic             irq
);
    logic              tick;
    logic              expire;
    logic [CFG_W-1:0]  cfg_word;
    logic [LEFT_W-1:0] left_cnt;
    logic [CNT_W-1:0]  free_cnt;

    ctmr_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ctmr_free_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (free_cnt)
    );

    ctmr_countdown #(.CFG_W(CFG_W), .LEFT_W(LEFT_W)) u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .irq_clr   (irq_clr),
        .cfg_word  (cfg_word),
        .left_cnt  (left_cnt),
        .irq       (irq),
        .expire    (expire)
    );

    always_comb begin
        unique case (ctmr_sel_e'(rd_sel))
            SEL_WORD: rd_data = cfg_word;
            SEL_LEFT: rd_data = CFG_W'(left_cnt);
            SEL_CNT:  rd_data = CFG_W'(free_cnt);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker #(
    parameter int unsigned CFG_W  = 64,
    parameter int unsigned LEFT_W = 48,
    parameter int unsigned CNT_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              expire,
    input logic              cfg_we,
    input logic [CFG_W-1:0]  cfg_wdata,
    input logic              irq_clr,
    input logic [CFG_W-1:0]  cfg_word,
    input logic [LEFT_W-1:0] left_cnt,
    input logic [CNT_W-1:0]  free_cnt,
    input logic              irq
);
    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_word == $past(cfg_wdata)); // R1

    AST_LEFT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cfg_we) |=> $stable(left_cnt)); // R3

    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && cfg_word[1]) |=> left_cnt == {$past(cfg_word[LEFT_W-1:2]), 2'b00}); // R4

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !cfg_word[1]) |=> (!cfg_word[0] && cfg_word[CFG_W-1:1] == $past(cfg_word[CFG_W-1:1]))); // R5

    AST_EXPIRY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq); // R6

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R6

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !expire) |=> !irq); // R6

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> free_cnt == CNT_W'($past(free_cnt) + 1'b1)); // R9

    AST_CNT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(free_cnt)); // R10

endmodule

bind cpu_const_timer ctmr_checker #(
    .CFG_W  (CFG_W),
    .LEFT_W (LEFT_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .expire    (expire),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .irq_clr   (irq_clr),
    .cfg_word  (cfg_word),
    .left_cnt  (left_cnt),
    .free_cnt  (free_cnt),
    .irq       (irq)
);

// File: tb/tb_cpu_const_timer.sv
`timescale 1ns/1ps
module tb_cpu_const_timer;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [63:0] cfg_wdata = '0;
    logic        irq_clr = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [63:0] rd_data;
    logic        irq;

    int     n_chk = 0;
    int     n_bad = 0;
    int     p = 0;
    longint ticks_total = 0;
    bit     t;

    always #10 clk = ~clk;

    cpu_const_timer #(.TICK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .irq_clr(irq_clr), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(output bit was_tick);
        was_tick = (p % DIV == DIV - 1);
        @(posedge clk);
        p++;
        if (was_tick) ticks_total++;
        @(negedge clk);
    endtask

    task automatic to_tick_cycle();
        bit w;
        while (p % DIV != DIV - 1) step(w);
    endtask

    task automatic avoid_tick();
        bit w;
        if (p % DIV == DIV - 1) step(w);
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit w;
            w = 1'b0;
            while (!w) step(w);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [63:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic write_cfg(input logic [63:0] v);
        bit w;
        avoid_tick();
        cfg_we = 1'b1;
        cfg_wdata = v;
        step(w);
        cfg_we = 1'b0;
    endtask

    task automatic clear_irq();
        bit w;
        avoid_tick();
        irq_clr = 1'b1;
        step(w);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        rd(2'd0, v); chk("R11 word", v, 64'd0);
        rd(2'd1, v); chk("R11 left", v, 64'd0);
        rd(2'd2, v); chk("R11 counter", v, 64'd0);
        rd(2'd3, v); chk("R9 sel3 zero", v, 64'd0);
        chk("R11 irq", {63'd0, irq}, 64'd0);
    endtask

    task automatic t_counter();
        logic [63:0] a, b;
        bit w;
        run_ticks(5);
        rd(2'd2, a); chk("R9 counter after ticks", a, 64'(ticks_total));
        for (int i = 0; i < DIV - 1; i++) step(w);
        rd(2'd2, b); chk("R10 counter still between ticks", b, a);
        step(w);
        rd(2'd2, b); chk("R10 counter steps on pulse", b, a + 64'd1);
    endtask

    task automatic t_oneshot();
        logic [63:0] v;
        write_cfg(64'hA500_0000_0000_0009);
        rd(2'd1, v); chk("R2 load masked", v, 64'd8);
        run_ticks(7);
        rd(2'd1, v); chk("R3 left after 7", v, 64'd1);
        chk("R3 no early irq", {63'd0, irq}, 64'd0);
        run_ticks(1);
        chk("R6 oneshot irq", {63'd0, irq}, 64'd1);
        rd(2'd0, v); chk("R5 enable cleared only", v, 64'hA500_0000_0000_0008);
        rd(2'd1, v); chk("R5 left zero", v, 64'd0);
        clear_irq();
        chk("R6 clear drops", {63'd0, irq}, 64'd0);
        run_ticks(4);
        chk("R5 no second expiry", {63'd0, irq}, 64'd0);
    endtask

    task automatic t_mask();
        logic [63:0] v;
        write_cfg(64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd0, v); chk("R1 readback all ones", v, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd1, v); chk("R2 mask 47..2", v, 64'h0000_FFFF_FFFF_FFFC);
        write_cfg(64'd0);
        rd(2'd1, v); chk("R7 stop clears left", v, 64'd0);
    endtask

    task automatic t_periodic();
        logic [63:0] v;
        bit w;
        write_cfg(64'h7);
        run_ticks(4);
        chk("R4 first expiry irq", {63'd0, irq}, 64'd1);
        rd(2'd1, v); chk("R4 reload", v, 64'd4);
        rd(2'd0, v); chk("R4 word kept", v, 64'h7);
        clear_irq();
        run_ticks(3);
        chk("R6 no irq before second", {63'd0, irq}, 64'd0);
        run_ticks(1);
        chk("R4 second expiry irq", {63'd0, irq}, 64'd1);
        run_ticks(3);
        to_tick_cycle();
        irq_clr = 1'b1;
        step(w);
        irq_clr = 1'b0;
        chk("R6 expiry beats clear", {63'd0, irq}, 64'd1);
        rd(2'd1, v); chk("R4 reload at collision", v, 64'd4);
        clear_irq();
        chk("R6 quiet clear", {63'd0, irq}, 64'd0);
        write_cfg(64'd0);
    endtask

    task automatic t_stop();
        logic [63:0] v;
        write_cfg(64'h21);
        run_ticks(2);
        rd(2'd1, v); chk("R3 left counts down", v, 64'h1E);
        write_cfg(64'h20);
        rd(2'd1, v); chk("R7 left zero", v, 64'd0);
        rd(2'd0, v); chk("R7 word stored", v, 64'h20);
        run_ticks(40);
        chk("R7 no irq after stop", {63'd0, irq}, 64'd0);
        rd(2'd1, v); chk("R7 left stays zero", v, 64'd0);
    endtask

    task automatic t_restart();
        logic [63:0] v;
        write_cfg(64'h31);
        run_ticks(3);
        rd(2'd1, v); chk("R3 left 0x2D", v, 64'h2D);
        write_cfg(64'h9);
        rd(2'd1, v); chk("R8 restart value", v, 64'd8);
        run_ticks(7);
        chk("R8 not yet", {63'd0, irq}, 64'd0);
        run_ticks(1);
        chk("R8 expiry from new value", {63'd0, irq}, 64'd1);
        clear_irq();
    endtask

    task automatic t_zero();
        logic [63:0] v;
        write_cfg(64'h1);
        rd(2'd1, v); chk("R3 zero load", v, 64'd0);
        chk("R3 zero no irq yet", {63'd0, irq}, 64'd0);
        run_ticks(1);
        chk("R3 zero expires next tick", {63'd0, irq}, 64'd1);
        rd(2'd0, v); chk("R5 zero oneshot word", v, 64'd0);
        clear_irq();
    endtask

    task automatic t_write_on_expiry();
        logic [63:0] v;
        bit w;
        write_cfg(64'h5);
        run_ticks(3);
        rd(2'd1, v); chk("R3 left one", v, 64'd1);
        to_tick_cycle();
        cfg_we = 1'b1;
        cfg_wdata = 64'hD;
        step(w);
        cfg_we = 1'b0;
        chk("R8 write cancels expiry", {63'd0, irq}, 64'd0);
        rd(2'd1, v); chk("R8 left from write", v, 64'hC);
        rd(2'd0, v); chk("R1 word from write", v, 64'hD);
        write_cfg(64'd0);
    endtask

    bit done = 1'b0;

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        p = 0;
        t_reset();
        t_counter();
        t_oneshot();
        t_mask();
        t_periodic();
        t_stop();
        t_restart();
        t_zero();
        t_write_on_expiry();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule